// File: doc/BRIEF.md
# SPI Slave with Held Receive Byte

This block is the target side of a four-wire serial link. Before the master opens a transfer, local logic presents a byte on a parallel input and pulses a load strobe. That byte goes into the slave's shift register. When the master pulls the active-low select line down and runs the serial clock, the slave sends the shift register out on MISO, most significant bit first, and takes in the master's bits from MOSI. After the master has sent eight bits, the two shift registers have swapped contents.

After the eighth bit the slave stops reacting to the serial lines and keeps the received byte. It holds that byte until local logic pulses a read strobe. The read strobe copies the byte into a parallel read-data register and returns the controller to its idle state, ready for the next load. If the select line rises part way through a byte, the bit counter clears and the controller stays idle.

All serial inputs are brought into the local clock domain through two-flop synchronisers. The local clock must therefore run several times faster than the serial clock.

Top module: `spi_slave_buf`

## Requirements
- R1: An asynchronous active-low reset clears the shift register and the read-data register and puts the controller in idle. A transfer run straight after reset with no load returns 0x00 to the master.
- R2: A load strobe in idle with select high copies the parallel byte into the shift register. Once select falls, MISO shows bit 7 of that byte before the first serial clock.
- R3: A load strobe has no effect while select is low, and no effect while a received byte is waiting to be read.
- R4: Bits travel most significant first. MOSI is sampled on the rising serial clock edge and MISO advances after the falling edge. After eight bits the master has received the loaded byte and the slave holds the master's byte.
- R5: A read strobe while a received byte is waiting copies it into the read-data register and returns the controller to idle. A read strobe in idle leaves the read-data register unchanged.
- R6: While select is high, MISO sits at the idle level (0 by default) and serial clock edges do not change the shift register.
- R7: If select rises before the eighth bit, the bit counter clears and the controller stays idle. A following read strobe does nothing. The next transfer counts a full eight bits and shifts on from the partly shifted contents.
- R8: After the eighth bit, further serial clock edges are ignored until the read strobe.
- R9: Successive load, transfer and read cycles work back to back with no other action between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sck_i | input | 1 | Serial clock from the master, idle low |
| ss_n_i | input | 1 | Slave select, active low |
| mosi_i | input | 1 | Serial data from the master |
| load_i | input | 1 | Strobe that loads the byte to be sent |
| load_data_i | input | DATA_W | Byte to be sent to the master |
| read_i | input | 1 | Strobe that copies the received byte out |
| miso_o | output | 1 | Serial data to the master |
| rdata_o | output | DATA_W | Last byte read out |

## Verification
The bench aims at four corner cases.
- A select that rises after three bits: a design that kept its count would finish the next transfer early and hand over a shifted byte.
- Load strobes pulsed while select is low, and again while a byte is waiting: a design that obeyed them would send or keep the wrong byte.
- Extra serial clocks after the eighth bit, and clocks with select high: a design that obeyed them would corrupt the waiting byte.
- A read strobe in idle: a design that obeyed it would overwrite the read-data register with stale contents.

// File: rtl/spi_slave_buf.sv
`timescale 1ns/1ps
module spi_slave_buf #(
  parameter int DATA_W   = 8,
  parameter bit IDLE_LVL = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck_i,
  input  logic              ss_n_i,
  input  logic              mosi_i,
  input  logic              load_i,
  input  logic [DATA_W-1:0] load_data_i,
  input  logic              read_i,
  output logic              miso_o,
  output logic [DATA_W-1:0] rdata_o
);

  localparam int CNT_W = (DATA_W > 2) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  typedef enum logic {ST_IDLE, ST_STORE} st_t;

  st_t               state;
  logic [DATA_W-1:0] shreg;
  logic [CNT_W-1:0]  cnt;
  logic              cap;
  logic [2:0]        sck_p;
  logic [1:0]        ss_p;
  logic [1:0]        mosi_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_p  <= '0;
      ss_p   <= 2'b11;
      mosi_p <= '0;
    end else begin
      sck_p  <= {sck_p[1:0], sck_i};
      ss_p   <= {ss_p[0], ss_n_i};
      mosi_p <= {mosi_p[0], mosi_i};
    end
  end

  wire active   = ~ss_p[1];
  wire shift_en = active & (state == ST_IDLE);
  wire rise     = shift_en &  sck_p[1] & ~sck_p[2];
  wire fall     = shift_en & ~sck_p[1] &  sck_p[2];

  assign miso_o = active ? shreg[DATA_W-1] : IDLE_LVL;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      shreg   <= '0;
      rdata_o <= '0;
      cnt     <= '0;
      cap     <= 1'b0;
    end else begin
      if (!active) cnt <= '0;
      case (state)
        ST_IDLE: begin
          if (load_i && !active) shreg <= load_data_i;
          if (rise) cap <= mosi_p[1];
          if (fall) begin
            shreg <= {shreg[DATA_W-2:0], cap};
            cnt   <= cnt + 1'b1;
            if (cnt == LAST) state <= ST_STORE;
          end
        end
        ST_STORE: begin
          if (read_i) begin
            rdata_o <= shreg;
            state   <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  p_read_copies_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_STORE && read_i) |=> (state == ST_IDLE && rdata_o == $past(shreg)));

  p_rdata_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(state == ST_STORE && read_i) |=> $stable(rdata_o));

  p_store_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_STORE && !read_i) |=> (state == ST_STORE && $stable(shreg)));

  p_desel_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && !active && !load_i) |=> $stable(shreg));

  p_load_blocked_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && active && !fall) |=> $stable(shreg));

  p_last_bit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fall && cnt == LAST) |=> (state == ST_STORE));

  p_abort_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ss_p[1]) && state == ST_IDLE) |=> (state == ST_IDLE && cnt == '0));

endmodule

// File: tb/spi_slave_buf_tb.sv
`timescale 1ns/1ps
module spi_slave_buf_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sck = 1'b0, ss_n = 1'b1, mosi = 1'b0;
  logic       load = 1'b0, rd = 1'b0;
  logic [7:0] ldata = '0;
  logic       miso;
  logic [7:0] rdata;

  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  spi_slave_buf #(.DATA_W(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .sck_i(sck), .ss_n_i(ss_n), .mosi_i(mosi),
    .load_i(load), .load_data_i(ldata), .read_i(rd),
    .miso_o(miso), .rdata_o(rdata));

  localparam logic [15:0] VEC [6] = '{16'hA5_3C, 16'h00_FF, 16'hFF_00,
                                      16'h81_7E, 16'h55_AA, 16'h96_69};

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_load(input logic [7:0] b);
    tick(1); ldata = b; load = 1'b1; tick(1); load = 1'b0; tick(4);
  endtask

  task automatic do_read();
    tick(1); rd = 1'b1; tick(1); rd = 1'b0; tick(4);
  endtask

  task automatic sel(input logic v);
    tick(1); ss_n = v; tick(10);
  endtask

  task automatic xfer(input logic [7:0] mo, input int nbits, output logic [7:0] mi);
    mi = '0;
    for (int i = 0; i < nbits; i++) begin
      mosi = mo[7-i];
      tick(5);
      mi[7-i] = miso;
      sck = 1'b1; tick(10);
      sck = 1'b0; tick(10);
    end
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      sck = 1'b1; tick(10); sck = 1'b0; tick(10);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    logic [7:0] got;
    tick(3); rst_n = 1'b1; tick(3);
    // R1 reset state, R6 idle level
    chk("R1 rdata after reset", rdata, 8'h00);
    chk("R6 miso idle after reset", {7'b0, miso}, 8'h00);
    sel(1'b0); xfer(8'h3C, 8, got); sel(1'b1);
    chk("R1 cleared shift register sent", got, 8'h00);
    do_read();
    chk("R4 received after reset", rdata, 8'h3C);

    // R9 back-to-back table: slave byte, master byte
    for (int k = 0; k < 6; k++) begin
      do_load(VEC[k][15:8]);
      sel(1'b0); xfer(VEC[k][7:0], 8, got); sel(1'b1);
      chk("R4 R9 master received loaded byte", got, VEC[k][15:8]);
      do_read();
      chk("R5 R9 rdata holds master byte", rdata, VEC[k][7:0]);
    end

    // R6 edges with select high, R2 MSB on select fall
    do_load(8'h81);
    pulses(5);
    chk("R6 miso idle while deselected", {7'b0, miso}, 8'h00);
    sel(1'b0);
    chk("R2 msb shown before first clock", {7'b0, miso}, 8'h01);
    xfer(8'hC5, 8, got);
    chk("R6 edges while deselected ignored", got, 8'h81);
    // R3 load in store, R8 extra edges in store
    do_load(8'h00);
    pulses(3);
    sel(1'b1);
    do_read();
    chk("R8 R3 held byte survives", rdata, 8'hC5);

    // R3 load while select low
    do_load(8'h5A);
    sel(1'b0);
    do_load(8'hFF);
    xfer(8'h12, 8, got); sel(1'b1);
    chk("R3 load ignored while selected", got, 8'h5A);
    do_read();
    chk("R3 R5 rdata after transfer", rdata, 8'h12);

    // R5 read in idle ignored
    do_read();
    chk("R5 read in idle ignored", rdata, 8'h12);

    // R7 aborted transfer
    do_load(8'hC3);
    sel(1'b0); xfer(8'hE0, 3, got); sel(1'b1);
    do_read();
    chk("R7 read after abort ignored", rdata, 8'h12);
    sel(1'b0); xfer(8'h42, 8, got); sel(1'b1);
    chk("R7 shifted contents after abort", got, 8'h1F);
    do_read();
    chk("R7 full count after abort", rdata, 8'h42);

    // R1 asynchronous reset mid-hold
    do_load(8'hF0);
    sel(1'b0); xfer(8'h99, 8, got); sel(1'b1);
    #3 rst_n = 1'b0; tick(2); rst_n = 1'b1; tick(3);
    chk("R1 rdata cleared by reset", rdata, 8'h00);
    do_read();
    chk("R1 idle after reset read ignored", rdata, 8'h00);

    finish_up();
  end
endmodule